// File: doc/BRIEF.md
# Primed Unaligned Vector Load Streamer

This block serves a stream of vector loads whose start address need not sit on a block boundary. The local buffer can only return whole aligned blocks. A priming command names a start byte address. The block fetches the aligned block that holds that address and keeps it as alignment state, together with the byte offset of the address inside the block.

Each following stream-load command makes exactly one new aligned fetch. It joins the tail of the held block with the head of the fetched block to form one full vector. It returns that vector together with the updated alignment state and the next base pointer. Because the state is carried from load to load, a primed stream completes one load per cycle.

Two kinds of command are refused and reported as errors. One is a load that has no primed state behind it. The other is any access that leaves the local buffer window. Per-lane enables only clear result lanes; they never excuse an illegal address.

Top module: `uvl_stream`

## Requirements
- R1: After reset, `res_valid` and `rd_en` are 0 and `cmd_ready` is 1, and no primed state exists.
- R2: An accepted command that is legal asserts `rd_en` in the same cycle with a block-aligned `rd_addr` (low log2(VB) bits zero) inside the window. A prime (`cmd_op`=0) reads the block holding `cmd_addr` and produces no result.
- R3: A legal load (`cmd_op`=1) whose base has a nonzero offset fetches only the block at aligned(base)+VB. Byte j of `res_vec` (bits 8j+7..8j) equals buffer byte base+j, for j from 0 to VB-1.
- R4: A legal load whose base offset is zero fetches the block at the base itself, and `res_vec` equals that fetched block.
- R5: A load ignores `cmd_addr`. It returns `res_next_base` = base+VB, `res_align_off` = that next base modulo VB, and `res_align_blk` = the block it just fetched. The next load starts from that next base.
- R6: Each load or refused command yields exactly one result, with `res_valid` high in the cycle after acceptance. With `res_ready` held high, `cmd_ready` stays high, so one load completes per cycle.
- R7: A load with no primed state returns `res_err`=2 and an all-zero vector, and issues no read.
- R8: A prime whose address is outside [window low, window high), or a load whose VB bytes do not all lie in the window, returns `res_err`=1 and issues no read. The base and the primed state are left as they were.
- R9: When bit i of `cmd_lane_en` is 0, lane i (bits 32i+31..32i) of `res_vec` is zero. Errors are reported exactly as in R7 and R8 even with every lane disabled.
- R10: While `res_valid` is high and `res_ready` is low, `cmd_ready` is low, and the result outputs stay unchanged in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| cmd_op | input | 1 | 0 = prime, 1 = stream-load |
| cmd_addr | input | ADDR_W | Start byte address for a prime; ignored for loads |
| cmd_lane_en | input | LANES | Per-lane result enables |
| rd_en | output | 1 | Local buffer block read strobe |
| rd_addr | output | ADDR_W | Aligned byte address of the block to read |
| rd_data | input | LANES*ELEM_W | Block returned one cycle after `rd_en`, held until the next read |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken when high together with `res_valid` |
| res_vec | output | LANES*ELEM_W | Assembled vector |
| res_align_blk | output | LANES*ELEM_W | Aligned block kept as the new alignment state |
| res_align_off | output | log2(VB) | Byte offset held in the alignment state |
| res_next_base | output | ADDR_W | Base pointer for the next load |
| res_err | output | 2 | 0 none, 1 out of window, 2 not primed |

## Verification
The assertions rely on the buffer behaving as a one-cycle synchronous read that keeps `rd_data` steady until the next `rd_en`. The bench models the buffer exactly that way, and every buffer byte is a fixed function of its address. The assertions also assume that commands and result acceptance are driven away from the clock edge; the bench changes all inputs only on the falling edge. Random prime addresses reach somewhat past both ends of the window, so range errors, re-priming and loads run off the top of the window all come up under both steady and withheld `res_ready`.

// File: rtl/uvl_pkg.sv
package uvl_pkg;

  // Result error codes, also the values seen on res_err
  typedef enum logic [1:0] {
    UVL_OK          = 2'd0,
    UVL_ERR_RANGE   = 2'd1,
    UVL_ERR_NOPRIME = 2'd2
  } uvl_err_e;

  typedef enum logic {
    UVL_PRIME = 1'b0,
    UVL_LOAD  = 1'b1
  } uvl_op_e;

endpackage

// File: rtl/uvl_range_chk.sv
// Decides legality of a command and the aligned block it must fetch.
module uvl_range_chk
  import uvl_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          VB         = 256,
  parameter int unsigned WIN_BASE   = 32'h4000,
  parameter int unsigned WIN_BLOCKS = 32
) (
  input  logic              is_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              primed,
  output uvl_err_e          err,
  output logic [ADDR_W-1:0] fetch_addr
);

  localparam int OFF_W = $clog2(VB);
  localparam int EXT_W = ADDR_W + 2;
  localparam logic [EXT_W-1:0] WIN_LO = EXT_W'(WIN_BASE);
  localparam logic [EXT_W-1:0] WIN_HI = EXT_W'(WIN_BASE + WIN_BLOCKS * VB);

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // True when bytes a .. a+n-1 all lie inside the window
  function automatic logic span_inside(input logic [ADDR_W-1:0] a, input logic [EXT_W-1:0] n);
    logic [EXT_W-1:0] ext;
    ext = {2'b00, a};
    return (ext >= WIN_LO) && ((ext + n) <= WIN_HI);
  endfunction

  // Block a load needs: the base block itself when aligned, else the next one
  function automatic logic [ADDR_W-1:0] load_fetch(input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] step;
    step = (b[OFF_W-1:0] != '0) ? ADDR_W'(VB) : '0;
    return align_down(b) + step;
  endfunction

  always_comb begin
    err        = UVL_OK;
    fetch_addr = align_down(cmd_addr);
    if (!is_load) begin
      if (!span_inside(cmd_addr, EXT_W'(1))) err = UVL_ERR_RANGE;
    end else begin
      fetch_addr = load_fetch(base);
      if (!primed)                              err = UVL_ERR_NOPRIME;
      else if (!span_inside(base, EXT_W'(VB)))  err = UVL_ERR_RANGE;
    end
  end

endmodule

// File: rtl/uvl_byte_merge.sv
// Holds the alignment block and assembles the output vector.
module uvl_byte_merge #(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap,
  input  logic [LANES*ELEM_W-1:0]      fetched,
  input  logic [$clog2(LANES*ELEM_W/8)-1:0] off,
  input  logic [LANES-1:0]             lane_en,
  input  logic                         ok,
  output logic [LANES*ELEM_W-1:0]      vec,
  output logic [LANES*ELEM_W-1:0]      state_blk
);

  localparam int VW    = LANES * ELEM_W;
  localparam int VB    = VW / 8;
  localparam int OFF_W = $clog2(VB);

  logic [VW-1:0] held_q;
  logic [VW-1:0] spliced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (cap) held_q <= fetched;
  end

  // Bytes off..VB-1 of the held block followed by bytes 0..off-1 of the new one
  function automatic logic [VW-1:0] splice(input logic [VW-1:0] lo_blk,
                                           input logic [VW-1:0] hi_blk,
                                           input logic [OFF_W-1:0] sh);
    logic [2*VW-1:0] both;
    both = {hi_blk, lo_blk} >> {sh, 3'b000};
    return (sh == '0) ? hi_blk : both[VW-1:0];
  endfunction

  assign spliced   = splice(held_q, fetched, off);
  assign state_blk = ok ? fetched : held_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign vec[g*ELEM_W +: ELEM_W] = (ok && lane_en[g]) ? spliced[g*ELEM_W +: ELEM_W] : '0;
  end

endmodule

// File: rtl/uvl_seq_ctrl.sv
// Command acceptance, in-flight stage, base/prime state and result handshake.
module uvl_seq_ctrl
  import uvl_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          VB         = 256,
  parameter int          LANES      = 64,
  parameter int unsigned WIN_BASE   = 32'h4000,
  parameter int unsigned WIN_BLOCKS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_op,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [LANES-1:0]         cmd_lane_en,
  output logic                     cmd_ready,
  input  uvl_err_e                 chk_err,
  input  logic [ADDR_W-1:0]        chk_fetch,
  output logic                     primed,
  output logic [ADDR_W-1:0]        base,
  output logic                     rd_en,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic                     res_ready,
  output logic                     res_valid,
  output logic [1:0]               res_err,
  output logic                     s1_ok,
  output logic [$clog2(VB)-1:0]    s1_off,
  output logic [LANES-1:0]         s1_lane_en,
  output logic                     cap
);

  localparam int OFF_W = $clog2(VB);
  localparam int EXT_W = ADDR_W + 2;
  localparam logic [EXT_W-1:0] WIN_LO = EXT_W'(WIN_BASE);
  localparam logic [EXT_W-1:0] WIN_HI = EXT_W'(WIN_BASE + WIN_BLOCKS * VB);

  logic              primed_q;
  logic [ADDR_W-1:0] base_q;
  logic              s1_v_q, s1_emit_q;
  uvl_err_e          s1_err_q;
  logic [OFF_W-1:0]  s1_off_q;
  logic [LANES-1:0]  s1_lane_q;

  // Named internal events
  logic ev_accept, ev_issue, ev_emit_in, ev_retire, ev_is_load;

  assign ev_is_load = (uvl_op_e'(cmd_op) == UVL_LOAD);
  assign cmd_ready  = !(s1_v_q && s1_emit_q) || res_ready;
  assign ev_accept  = cmd_valid && cmd_ready;
  assign ev_issue   = ev_accept && (chk_err == UVL_OK);
  assign ev_emit_in = ev_is_load || (chk_err != UVL_OK);
  assign ev_retire  = s1_v_q && (!s1_emit_q || res_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      base_q    <= '0;
      s1_v_q    <= 1'b0;
      s1_emit_q <= 1'b0;
      s1_err_q  <= UVL_OK;
      s1_off_q  <= '0;
      s1_lane_q <= '0;
    end else begin
      if (ev_accept) begin
        s1_v_q    <= 1'b1;
        s1_emit_q <= ev_emit_in;
        s1_err_q  <= chk_err;
        s1_off_q  <= ev_is_load ? base_q[OFF_W-1:0] : cmd_addr[OFF_W-1:0];
        s1_lane_q <= cmd_lane_en;
      end else if (ev_retire) begin
        s1_v_q    <= 1'b0;
      end
      if (ev_issue) begin
        if (ev_is_load) begin
          base_q <= base_q + ADDR_W'(VB);
        end else begin
          primed_q <= 1'b1;
          base_q   <= cmd_addr;
        end
      end
    end
  end

  assign primed     = primed_q;
  assign base       = base_q;
  assign rd_en      = ev_issue;
  assign rd_addr    = chk_fetch;
  assign res_valid  = s1_v_q && s1_emit_q;
  assign res_err    = s1_err_q;
  assign s1_ok      = (s1_err_q == UVL_OK);
  assign s1_off     = s1_off_q;
  assign s1_lane_en = s1_lane_q;
  assign cap        = ev_retire && (s1_err_q == UVL_OK);

  // Every buffer read is block aligned and inside the window
  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr[OFF_W-1:0] == '0) && ({2'b00, rd_addr} >= WIN_LO)
              && (({2'b00, rd_addr} + EXT_W'(VB)) <= WIN_HI));

  // A good load moves the base forward by one vector
  assert_base_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_is_load && chk_err == UVL_OK) |=> base_q == $past(base_q) + ADDR_W'(VB));

  // A result appears the cycle after each load or refused command
  assert_one_cycle_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_emit_in) |=> res_valid);

  // A load with nothing primed reads nothing and reports the priming error
  assert_noprime_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_is_load && !primed_q) |-> !rd_en ##1 (res_err == 2'd2));

  // A refused command leaves base and prime state alone
  assert_err_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && chk_err != UVL_OK) |=> $stable(base_q) && $stable(primed_q));

  // A withheld result stays put
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(s1_off_q) && $stable(base_q)
                                   && $stable(s1_err_q));

endmodule

// File: rtl/uvl_stream.sv
module uvl_stream
  import uvl_pkg::*;
#(
  parameter int          LANES      = 64,
  parameter int          ELEM_W     = 32,
  parameter int          ADDR_W     = 20,
  parameter int unsigned WIN_BASE   = 32'h4000,
  parameter int unsigned WIN_BLOCKS = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cmd_valid,
  output logic                                 cmd_ready,
  input  logic                                 cmd_op,
  input  logic [ADDR_W-1:0]                    cmd_addr,
  input  logic [LANES-1:0]                     cmd_lane_en,
  output logic                                 rd_en,
  output logic [ADDR_W-1:0]                    rd_addr,
  input  logic [LANES*ELEM_W-1:0]              rd_data,
  output logic                                 res_valid,
  input  logic                                 res_ready,
  output logic [LANES*ELEM_W-1:0]              res_vec,
  output logic [LANES*ELEM_W-1:0]              res_align_blk,
  output logic [$clog2(LANES*ELEM_W/8)-1:0]    res_align_off,
  output logic [ADDR_W-1:0]                    res_next_base,
  output logic [1:0]                           res_err
);

  localparam int VW    = LANES * ELEM_W;
  localparam int VB    = VW / 8;
  localparam int OFF_W = $clog2(VB);

  uvl_err_e          chk_err;
  logic [ADDR_W-1:0] chk_fetch;
  logic              primed;
  logic [ADDR_W-1:0] base;
  logic              s1_ok;
  logic [OFF_W-1:0]  s1_off;
  logic [LANES-1:0]  s1_lane_en;
  logic              cap;

  uvl_range_chk #(
    .ADDR_W(ADDR_W), .VB(VB), .WIN_BASE(WIN_BASE), .WIN_BLOCKS(WIN_BLOCKS)
  ) u_chk (
    .is_load    (cmd_op),
    .cmd_addr   (cmd_addr),
    .base       (base),
    .primed     (primed),
    .err        (chk_err),
    .fetch_addr (chk_fetch)
  );

  uvl_seq_ctrl #(
    .ADDR_W(ADDR_W), .VB(VB), .LANES(LANES),
    .WIN_BASE(WIN_BASE), .WIN_BLOCKS(WIN_BLOCKS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_lane_en (cmd_lane_en),
    .cmd_ready   (cmd_ready),
    .chk_err     (chk_err),
    .chk_fetch   (chk_fetch),
    .primed      (primed),
    .base        (base),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_err     (res_err),
    .s1_ok       (s1_ok),
    .s1_off      (s1_off),
    .s1_lane_en  (s1_lane_en),
    .cap         (cap)
  );

  uvl_byte_merge #(
    .LANES(LANES), .ELEM_W(ELEM_W)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap),
    .fetched   (rd_data),
    .off       (s1_off),
    .lane_en   (s1_lane_en),
    .ok        (s1_ok),
    .vec       (res_vec),
    .state_blk (res_align_blk)
  );

  // The base register already holds the advanced pointer while the result is shown
  assign res_next_base = base;
  assign res_align_off = base[OFF_W-1:0];

endmodule

// File: tb/uvl_stream_test.sv
`timescale 1ns/1ps
module uvl_stream_test;

  localparam int LANES  = 64;
  localparam int ELEM_W = 32;
  localparam int ADDR_W = 20;
  localparam int VW     = LANES * ELEM_W;
  localparam int VB     = VW / 8;
  localparam int OFF_W  = 8;
  localparam int unsigned LO = 32'h4000;
  localparam int unsigned HI = 32'h6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, res_ready = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LANES-1:0]  cmd_lane_en = '0;
  logic cmd_ready, rd_en, res_valid;
  logic [ADDR_W-1:0] rd_addr, res_next_base;
  logic [VW-1:0] rd_data, res_vec, res_align_blk;
  logic [OFF_W-1:0] res_align_off;
  logic [1:0] res_err;

  always #2 clk = ~clk;  // 250 MHz

  uvl_stream uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lane_en(cmd_lane_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_vec(res_vec),
    .res_align_blk(res_align_blk), .res_align_off(res_align_off),
    .res_next_base(res_next_base), .res_err(res_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Buffer content: every byte a fixed function of its address
  function automatic logic [7:0] fb(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[19:16]};
  endfunction

  function automatic logic [VW-1:0] bytes_at(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] en);
    logic [VW-1:0] r;
    for (int j = 0; j < VB; j++) r[j*8 +: 8] = fb(a + ADDR_W'(j));
    for (int l = 0; l < LANES; l++) if (!en[l]) r[l*ELEM_W +: ELEM_W] = '0;
    return r;
  endfunction

  // Memory model: one-cycle read, data held between reads
  logic [VW-1:0] mem_q = '0;
  always @(posedge clk) if (rd_en) mem_q <= bytes_at(rd_addr, '1);
  assign rd_data = mem_q;

  task automatic chk1(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkv(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Reference state
  logic              m_primed = 1'b0;
  logic [ADDR_W-1:0] m_base = '0;

  typedef struct {
    logic [VW-1:0]     vec;
    logic [VW-1:0]     blk;
    logic [ADDR_W-1:0] nb;
    logic [1:0]        err;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  bit expect_res = 0, stall_pend = 0;
  logic [VW-1:0] stall_vec;
  logic [ADDR_W-1:0] stall_nb;
  logic [1:0] stall_err;
  logic last_ready;

  function automatic logic in_win(input logic [ADDR_W-1:0] a, input int unsigned n);
    return (int'(a) >= int'(LO)) && (int'(a) + int'(n) <= int'(HI));
  endfunction

  task automatic model_accept(input logic op, input logic [ADDR_W-1:0] a, input logic [LANES-1:0] en);
    logic [1:0] err;
    logic [ADDR_W-1:0] fetch;
    exp_t e;
    string tag;
    err = 2'd0;
    if (!op) begin
      fetch = {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      if (!in_win(a, 1)) err = 2'd1;
    end else begin
      fetch = {m_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + ((m_base[OFF_W-1:0] != 0) ? ADDR_W'(VB) : '0);
      if (!m_primed) err = 2'd2;
      else if (!in_win(m_base, VB)) err = 2'd1;
    end
    chk1(rd_en, (err == 0), (err == 0) ? "R2" : "R8", "read strobe on accept");
    if (err == 0) chk1(rd_addr, fetch, op ? "R3" : "R2", "fetch address");
    if (op || err != 0) begin
      e.err = err;
      e.blk = bytes_at(fetch, '1);
      if (err == 0) begin
        e.vec = bytes_at(m_base, en);
        e.nb  = m_base + ADDR_W'(VB);
      end else begin
        e.vec = '0;
        e.nb  = m_base;
      end
      if (err == 2) tag = "R7";
      else if (err == 1) tag = (en == '0) ? "R9" : "R8";
      else if (en != '1) tag = "R9";
      else if (m_base[OFF_W-1:0] == 0) tag = "R4";
      else tag = "R3";
      q.push_back(e);
      tq.push_back(tag);
      expect_res = 1;
    end
    if (err == 0) begin
      if (op) m_base = m_base + ADDR_W'(VB);
      else begin m_primed = 1'b1; m_base = a; end
    end
  endtask

  task automatic step(input logic v, input logic op, input logic [ADDR_W-1:0] a,
                      input logic [LANES-1:0] en, input logic rr);
    exp_t e;
    string tag;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_lane_en = en; res_ready = rr;
    #1;
    if (stall_pend) begin  // R10: held result unchanged
      chk1(res_valid, 1, "R10", "valid held");
      chkv(res_vec, stall_vec, "R10", "vector held");
      chk1(res_next_base, stall_nb, "R10", "next base held");
      chk1(res_err, stall_err, "R10", "error held");
    end
    if (expect_res) chk1(res_valid, 1, "R6", "result one cycle after command");
    expect_res = 0;
    if (res_valid && res_ready) begin
      if (q.size() == 0) begin
        chk1(1, 0, "R6", "result with no command");
      end else begin
        e = q.pop_front();
        tag = tq.pop_front();
        chk1(res_err, e.err, tag, "error code");
        chkv(res_vec, e.vec, tag, "vector");
        chk1(res_next_base, e.nb, "R5", "next base");
        chk1(res_align_off, e.nb[OFF_W-1:0], "R5", "align offset");
        if (e.err == 0) chkv(res_align_blk, e.blk, "R5", "align block");
      end
    end
    stall_pend = res_valid && !res_ready;
    if (stall_pend) begin
      stall_vec = res_vec; stall_nb = res_next_base; stall_err = res_err;
      chk1(cmd_ready, 0, "R10", "command port stalled");
    end
    last_ready = cmd_ready;
    if (v && cmd_ready) model_accept(op, a, en);
    else chk1(rd_en, 0, "R2", "no read without accepted command");
  endtask

  initial begin
    logic [ADDR_W-1:0] ra;
    logic [LANES-1:0]  le;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk1(res_valid, 0, "R1", "res_valid after reset");
    chk1(cmd_ready, 1, "R1", "cmd_ready after reset");
    chk1(rd_en, 0, "R1", "rd_en after reset");

    // R7: load with nothing primed
    step(1, 1, 20'h04100, '1, 1);
    step(0, 0, 0, '1, 1);

    // R3/R6/R5: prime at offset 0x13, back-to-back loads, junk cmd_addr
    step(1, 0, 20'h04013, '1, 1);
    for (int i = 0; i < 6; i++) begin
      step(1, 1, ADDR_W'($urandom), '1, 1);
      chk1(last_ready, 1, "R6", "no bubble in stream");
    end

    // R4: aligned prime
    step(1, 0, 20'h04800, '1, 1);
    step(1, 1, 0, '1, 1);
    step(1, 1, 0, '1, 1);
    // R9: partial lane enables
    step(1, 1, 0, 64'h0F0F_0000_FFFF_1234, 1);
    step(1, 1, 0, 64'h8000_0000_0000_0001, 1);

    // R8: run off the top of the window
    step(1, 0, 20'h05E80, '1, 1);
    step(1, 1, 0, '1, 1);
    step(1, 1, 0, '1, 1);
    step(1, 1, 0, '0, 1);            // R9: all lanes off, still an error
    step(1, 0, 20'h03FFC, '1, 1);    // prime below window
    step(1, 0, 20'h06000, '1, 1);    // prime at window end
    step(1, 1, 0, '1, 1);            // base unchanged, still out
    step(1, 0, 20'h04005, '1, 1);
    step(1, 1, 0, '1, 1);

    // R10: backpressure
    step(1, 1, 0, '1, 0);
    step(1, 1, 0, '1, 0);
    step(1, 1, 0, '1, 0);
    step(1, 1, 0, '1, 1);
    step(0, 0, 0, '1, 1);

    // Random stream
    for (int i = 0; i < 4000; i++) begin
      ra = ADDR_W'(32'h3C00 + $urandom_range(0, 32'h2800));
      le = ($urandom_range(0, 9) < 7) ? '1 : {$urandom, $urandom};
      step($urandom_range(0, 99) < 85, $urandom_range(0, 99) >= 12,
           ra, le, $urandom_range(0, 3) != 0);
    end

    for (int i = 0; i < 6; i++) step(0, 0, 0, '1, 1);
    chk1(q.size(), 0, "R6", "every command answered");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule